// File: doc/BRIEF.md
# Atomic fetch-and-modify memory unit

This block carries out one indivisible read-modify-write on a synchronous memory port for a processor pipeline. The pipeline hands it a decoded request made of a function code, a sub-code, a byte address and the value of the rt source register. The unit reads the addressed 64-bit memory row, forms the new value, writes it back to the same row, and then pulses a completion strobe. Nothing else reaches the port in between. For the fetching flavours it also returns the value that memory held before the update, so that the pipeline can write it to a destination register.

The supported flavours are add, increment, decrement, set-all-ones, clear and swap. Each one has a 32-bit word form and a 64-bit doubleword form. Two store-only add codes update memory and return nothing. Requests with unknown codes or bad alignment finish at once with an error flag and never reach the memory port.

Top module: `amo_unit`

## Requirements
- R1: After reset, and until a request arrives, `done_o`, `mem_en_o`, `mem_we_o`, `rd_we_o`, `illegal_o` and `misalign_o` are all low.
- R2: Function code 0x18 (word) and function code 0x19 (doubleword) add rt to memory and store the sum. They complete with `rd_we_o` low and `rd_data_o` zero.
- R3: Function code 0x1F selects the fetching group, and the sub-code picks the operation. Bit 0 of the sub-code set means doubleword and clear means word. Bits 4:1 of the sub-code give the operation: 1 increment, 3 decrement, 5 set all ones, 7 clear, 9 add rt, 11 swap in rt.
- R4: Increment adds one and decrement subtracts one. Both wrap modulo 2^32 for words and modulo 2^64 for doublewords.
- R5: Set writes all ones to the operand and clear writes zero to it.
- R6: Add stores memory plus rt, wrapping at the operand width. Swap stores rt.
- R7: A fetching operation completes with `rd_we_o` high. `rd_data_o` then holds the memory operand from before the update. For words this value is sign-extended from bit 31.
- R8: A word operation uses only bits 31:0 of rt. A word at byte address bit 2 = 0 occupies data bits 31:0 of the 64-bit row, and bit 2 = 1 means bits 63:32. The other half of the row is left unchanged.
- R9: These requests complete with `illegal_o` high, with no memory read or write and with `rd_we_o` low:
  - any other function code;
  - any other sub-code under 0x1F.
- R10: A legal word request whose address is not a multiple of 4 completes with `misalign_o` high, with no memory access and with `rd_we_o` low. The same holds for a legal doubleword request whose address is not a multiple of 8. `illegal_o` takes precedence, so both flags are never high together.
- R11: A request is accepted on a clock edge when the unit is idle. The timing of a legal request after the accepting edge is as follows:
  - The read is presented in the first cycle.
  - The write to the same row is presented in the third cycle.
  - `done_o` is high for the fourth cycle only.
  
  An erroneous request has `done_o` high in the first cycle. Requests presented while an operation is in flight are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_func_i | input | 6 | Function code |
| req_sub_i | input | 5 | Sub-code for the fetching group |
| req_addr_i | input | ADDR_W | Byte address |
| req_rt_i | input | DATA_W | rt operand |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write (read when low) |
| mem_addr_o | output | ADDR_W | Row-aligned byte address |
| mem_be_o | output | DATA_W/8 | Byte enables for the write |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, one cycle after the read |
| done_o | output | 1 | Operation complete (one cycle) |
| rd_we_o | output | 1 | Destination register write |
| rd_data_o | output | DATA_W | Old memory value, word forms sign-extended |
| illegal_o | output | 1 | Unrecognised code, valid with done |
| misalign_o | output | 1 | Misaligned address, valid with done |

## Verification
The assertions watch the port ordering on every cycle:
- a write always follows a read to the same row by two cycles;
- a normal completion comes straight after a write;
- an erroneous completion never follows a memory access;
- completion lasts one cycle;
- a destination write appears only on a clean completion.

The arithmetic can only be shown by the bench's scenarios, which compare against a behavioural memory model. These scenarios cover the wrap at both widths, word lane selection, preservation of the other half of the row, sign extension and the ignoring of requests while busy.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_INC = 3'd1,
    OP_DEC = 3'd2,
    OP_SET = 3'd3,
    OP_CLR = 3'd4,
    OP_SWP = 3'd5
  } amo_op_e;

  typedef struct packed {
    amo_op_e op;
    logic    dbl;   // doubleword form
    logic    ret;   // returns old value to a register
    logic    bad;   // unrecognised code
  } amo_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } amo_state_e;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter logic [5:0] FN_STORE_W = 6'h18,
  parameter logic [5:0] FN_STORE_D = 6'h19,
  parameter logic [5:0] FN_FETCH   = 6'h1F
) (
  input  logic [5:0] func_i,
  input  logic [4:0] sub_i,
  output amo_cmd_t   cmd_o
);
  // R3: sub-code bits 4:1 pick the operation, bit 0 the width
  always_comb begin
    cmd_o.op  = OP_ADD;
    cmd_o.dbl = 1'b0;
    cmd_o.ret = 1'b0;
    cmd_o.bad = 1'b1;
    case (func_i)
      FN_STORE_W: begin
        cmd_o.bad = 1'b0;
      end
      FN_STORE_D: begin
        cmd_o.dbl = 1'b1;
        cmd_o.bad = 1'b0;
      end
      FN_FETCH: begin
        cmd_o.dbl = sub_i[0];
        cmd_o.ret = 1'b1;
        cmd_o.bad = 1'b0;
        case (sub_i[4:1])
          4'h1:    cmd_o.op = OP_INC;
          4'h3:    cmd_o.op = OP_DEC;
          4'h5:    cmd_o.op = OP_SET;
          4'h7:    cmd_o.op = OP_CLR;
          4'h9:    cmd_o.op = OP_ADD;
          4'hB:    cmd_o.op = OP_SWP;
          default: begin
            cmd_o.ret = 1'b0;
            cmd_o.bad = 1'b1;
          end
        endcase
      end
      default: cmd_o.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_op_e           op_i,
  input  logic              dbl_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] rt_i,
  output logic [DATA_W-1:0] new_o,
  output logic [DATA_W-1:0] ret_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] res_d;
  logic [HALF_W-1:0] res_w;
  logic [HALF_W-1:0] old_w;
  logic [HALF_W-1:0] rt_w;

  assign old_w = old_i[HALF_W-1:0];
  assign rt_w  = rt_i[HALF_W-1:0];

  always_comb begin
    case (op_i)
      OP_ADD:  res_d = old_i + rt_i;
      OP_INC:  res_d = old_i + DATA_W'(1);
      OP_DEC:  res_d = old_i - DATA_W'(1);
      OP_SET:  res_d = '1;
      OP_CLR:  res_d = '0;
      OP_SWP:  res_d = rt_i;
      default: res_d = old_i;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_ADD:  res_w = old_w + rt_w;
      OP_INC:  res_w = old_w + HALF_W'(1);
      OP_DEC:  res_w = old_w - HALF_W'(1);
      OP_SET:  res_w = '1;
      OP_CLR:  res_w = '0;
      OP_SWP:  res_w = rt_w;
      default: res_w = old_w;
    endcase
  end

  assign new_o = dbl_i ? res_d : {{HALF_W{1'b0}}, res_w};
  assign ret_o = dbl_i ? old_i : {{HALF_W{old_w[HALF_W-1]}}, old_w};
endmodule

// File: rtl/amo_lane.sv
module amo_lane #(
  parameter int DATA_W = 64
) (
  input  logic                dbl_i,
  input  logic                hi_i,
  input  logic [DATA_W-1:0]   rdata_i,
  input  logic [DATA_W-1:0]   new_i,
  output logic [DATA_W-1:0]   lane_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [DATA_W/8-1:0] be_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int HBE_W  = DATA_W / 16;

  logic [HALF_W-1:0] half_sel;

  assign half_sel = hi_i ? rdata_i[DATA_W-1:HALF_W] : rdata_i[HALF_W-1:0];
  assign lane_o   = dbl_i ? rdata_i : {{HALF_W{1'b0}}, half_sel};

  for (genvar g = 0; g < 2; g++) begin : g_half
    assign wdata_o[g*HALF_W +: HALF_W] =
      dbl_i ? new_i[g*HALF_W +: HALF_W] : new_i[HALF_W-1:0];
    assign be_o[g*HBE_W +: HBE_W] = {HBE_W{dbl_i | (hi_i == 1'(g))}};
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  input  logic [5:0]          req_func_i,
  input  logic [4:0]          req_sub_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_rt_i,
  output logic                mem_en_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                done_o,
  output logic                rd_we_o,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                illegal_o,
  output logic                misalign_o
);
  localparam int BE_W  = DATA_W / 8;
  localparam int OFF_W = $clog2(BE_W);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  amo_cmd_t cmd_d;
  amo_decode u_dec (
    .func_i (req_func_i),
    .sub_i  (req_sub_i),
    .cmd_o  (cmd_d)
  );

  logic misal_d;
  assign misal_d = cmd_d.dbl ? (|req_addr_i[OFF_W-1:0])
                             : (|req_addr_i[OFF_W-2:0]);

  amo_state_e st_q, st_d;
  amo_cmd_t   cmd_q;
  logic [ADDR_W-1:OFF_W] base_q;
  logic                  hi_q;
  logic [DATA_W-1:0]     rt_q;
  logic [DATA_W-1:0]     old_q;
  logic                  ill_q;
  logic                  mis_q;

  logic accept_en;
  logic capture_en;
  assign accept_en  = (st_q == ST_IDLE) && req_valid_i;
  assign capture_en = (st_q == ST_MODIFY);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (req_valid_i) st_d = (cmd_d.bad || misal_d) ? ST_DONE : ST_READ;
      ST_READ:   st_d = ST_MODIFY;
      ST_MODIFY: st_d = ST_WRITE;
      ST_WRITE:  st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cmd_q  <= '0;
      base_q <= '0;
      hi_q   <= 1'b0;
      rt_q   <= '0;
      ill_q  <= 1'b0;
      mis_q  <= 1'b0;
    end else if (accept_en) begin
      cmd_q  <= cmd_d;
      base_q <= req_addr_i[ADDR_W-1:OFF_W];
      hi_q   <= req_addr_i[OFF_W-1];
      rt_q   <= req_rt_i;
      ill_q  <= cmd_d.bad;
      mis_q  <= !cmd_d.bad && misal_d;
    end
  end

  logic [DATA_W-1:0] lane_val;
  logic [DATA_W-1:0] new_val;
  logic [DATA_W-1:0] ret_val;
  logic [DATA_W-1:0] wdata;
  logic [BE_W-1:0]   be;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)          old_q <= '0;
    else if (capture_en) old_q <= lane_val;
  end

  amo_lane #(.DATA_W(DATA_W)) u_lane (
    .dbl_i   (cmd_q.dbl),
    .hi_i    (hi_q),
    .rdata_i (mem_rdata_i),
    .new_i   (new_val),
    .lane_o  (lane_val),
    .wdata_o (wdata),
    .be_o    (be)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (cmd_q.op),
    .dbl_i (cmd_q.dbl),
    .old_i (old_q),
    .rt_i  (rt_q),
    .new_o (new_val),
    .ret_o (ret_val)
  );

  assign mem_en_o    = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we_o    = (st_q == ST_WRITE);
  assign mem_addr_o  = {base_q, {OFF_W{1'b0}}};
  assign mem_be_o    = mem_we_o ? be : '0;
  assign mem_wdata_o = mem_we_o ? wdata : '0;

  assign done_o     = (st_q == ST_DONE);
  assign illegal_o  = done_o && ill_q;
  assign misalign_o = done_o && mis_q;
  assign rd_we_o    = done_o && cmd_q.ret && !ill_q && !mis_q;
  assign rd_data_o  = rd_we_o ? ret_val : '0;

  // ordering checks on the memory port and the completion strobe
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_q)
    mem_we_o |-> $past(mem_en_o && !mem_we_o, 2)); // R11
  AST_WR_SAME_ROW: assert property (@(posedge clk) disable iff (!rst_q)
    mem_we_o |-> (mem_addr_o == $past(mem_addr_o, 2))); // R11
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_q)
    (done_o && !illegal_o && !misalign_o) |-> $past(mem_we_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |=> !done_o); // R11
  AST_ILLEGAL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_q)
    illegal_o |-> !$past(mem_en_o)); // R9
  AST_MISALIGN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_q)
    misalign_o |-> !$past(mem_en_o)); // R10
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_q)
    !(illegal_o && misalign_o)); // R10
  AST_RD_CLEAN_ONLY: assert property (@(posedge clk) disable iff (!rst_q)
    rd_we_o |-> (done_o && !illegal_o && !misalign_o)); // R7
endmodule

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [5:0]        req_func = '0;
  logic [4:0]        req_sub = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_rt = '0;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_be;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              done, rd_we, illegal, misalign;
  logic [DATA_W-1:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  amo_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_func_i(req_func),
    .req_sub_i(req_sub), .req_addr_i(req_addr), .req_rt_i(req_rt),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done), .rd_we_o(rd_we),
    .rd_data_o(rd_data), .illegal_o(illegal), .misalign_o(misalign)
  );

  // behavioural memory on the port, and the reference copy
  logic [63:0] bmem [int];
  logic [63:0] rmem [int];

  function automatic logic [63:0] get_b(int idx);
    return bmem.exists(idx) ? bmem[idx] : 64'd0;
  endfunction
  function automatic logic [63:0] get_r(int idx);
    return rmem.exists(idx) ? rmem[idx] : 64'd0;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        logic [63:0] v;
        v = get_b(int'(mem_addr[ADDR_W-1:3]));
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) v[b*8 +: 8] = mem_wdata[b*8 +: 8];
        bmem[int'(mem_addr[ADDR_W-1:3])] = v;
      end else begin
        mem_rdata <= get_b(int'(mem_addr[ADDR_W-1:3]));
      end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic preload(logic [15:0] ad, logic [63:0] v);
    bmem[int'(ad[15:3])] = v;
    rmem[int'(ad[15:3])] = v;
  endtask

  task automatic run_op(string tag, logic [5:0] fn, logic [4:0] sb,
                        logic [15:0] ad, logic [63:0] rt, bit probe);
    bit e_bad, e_mis, e_dbl, e_ret, legal;
    int kind, idx, done_n, tm_err;
    logic [63:0] row, e_rd, nv;
    logic [31:0] o32, n32;
    logic [15:0] p_ad;
    logic [63:0] p_before;
    bit got_done;
    logic [63:0] a_rd, a_rwe, a_ill, a_mis;
    e_bad = 1; e_ret = 0; e_dbl = 0; kind = 9;
    if (fn == 6'h18) begin e_bad = 0; end
    else if (fn == 6'h19) begin e_bad = 0; e_dbl = 1; end
    else if (fn == 6'h1F) begin
      kind = int'(sb[4:1]);
      if (kind == 1 || kind == 3 || kind == 5 || kind == 7 || kind == 9 || kind == 11) begin
        e_bad = 0; e_ret = 1; e_dbl = sb[0];
      end
    end
    e_mis = !e_bad && (e_dbl ? (ad[2:0] != 0) : (ad[1:0] != 0));
    legal = !e_bad && !e_mis;
    idx = int'(ad[15:3]);
    row = get_r(idx);
    e_rd = 64'd0;
    if (legal) begin
      if (e_dbl) begin
        case (kind)
          1: nv = row + 64'd1;
          3: nv = row - 64'd1;
          5: nv = '1;
          7: nv = '0;
          11: nv = rt;
          default: nv = row + rt;
        endcase
        if (e_ret) e_rd = row;
        rmem[idx] = nv;
      end else begin
        o32 = ad[2] ? row[63:32] : row[31:0];
        case (kind)
          1: n32 = o32 + 32'd1;
          3: n32 = o32 - 32'd1;
          5: n32 = '1;
          7: n32 = '0;
          11: n32 = rt[31:0];
          default: n32 = o32 + rt[31:0];
        endcase
        if (e_ret) e_rd = {{32{o32[31]}}, o32};
        if (ad[2]) row[63:32] = n32; else row[31:0] = n32;
        rmem[idx] = row;
      end
    end
    done_n = legal ? 4 : 1;
    p_ad = 16'h0060;
    p_before = get_b(int'(p_ad[15:3]));

    @(negedge clk);
    req_valid = 1; req_func = fn; req_sub = sb; req_addr = ad; req_rt = rt;
    @(negedge clk);
    if (probe) begin
      req_func = 6'h1F; req_sub = 5'h0B; req_addr = p_ad; req_rt = '0;
    end else req_valid = 0;
    tm_err = 0; got_done = 0;
    a_rd = '0; a_rwe = '0; a_ill = '0; a_mis = '0;
    for (int n = 1; n <= 5; n++) begin
      if (n > 1) @(negedge clk);
      if (probe && n == 3) req_valid = 0;
      if (done !== (n == done_n)) tm_err++;
      if (mem_en !== (legal && (n == 1 || n == 3))) tm_err++;
      if (mem_we !== (legal && n == 3)) tm_err++;
      if (done === 1'b1) begin
        got_done = 1;
        a_rd = rd_data; a_rwe = {63'd0, rd_we};
        a_ill = {63'd0, illegal}; a_mis = {63'd0, misalign};
      end
    end
    chk(tag, "cycle timing errors", tm_err, 0);
    chk(tag, "done seen", {63'd0, got_done}, 64'd1);
    chk(tag, "rd_we", a_rwe, {63'd0, e_ret && legal});
    chk(tag, "rd_data", a_rd, e_rd);
    chk(tag, "illegal", a_ill, {63'd0, e_bad});
    chk(tag, "misalign", a_mis, {63'd0, e_mis});
    chk(tag, "memory row", get_b(idx), get_r(idx));
    if (probe) chk(tag, "busy request ignored", get_b(int'(p_ad[15:3])), p_before);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "done", {63'd0, done}, 0);
    chk("R1", "mem_en", {63'd0, mem_en}, 0);
    chk("R1", "mem_we", {63'd0, mem_we}, 0);
    chk("R1", "rd_we", {63'd0, rd_we}, 0);
    chk("R1", "errors", {62'd0, illegal, misalign}, 0);

    preload(16'h0010, 64'hAAAA_BBBB_7FFF_FFFE);
    preload(16'h0020, 64'hFFFF_FFFF_FFFF_FFF0);
    preload(16'h0028, 64'h1234_5678_9ABC_DEF0);
    preload(16'h0030, 64'h0000_0000_0000_0000);
    preload(16'h0038, 64'hFFFF_FFFF_FFFF_FFFF);
    preload(16'h0040, 64'h8000_0000_0000_0001);
    preload(16'h0048, 64'hDEAD_BEEF_CAFE_F00D);
    preload(16'h0060, 64'h0102_0304_0506_0708);

    // R2 and R8: store add word, upper half of rt ignored, other half kept
    run_op("R2_R8", 6'h18, 5'h00, 16'h0010, 64'hFFFF_FFFF_0000_0003, 0);
    run_op("R2", 6'h19, 5'h00, 16'h0020, 64'h0000_0000_0000_0020, 0);
    // R4: wrap at both widths; R7 sign extension; R8 upper lane
    run_op("R4_R7", 6'h1F, 5'h02, 16'h003C, 64'h0, 0);
    run_op("R4", 6'h1F, 5'h07, 16'h0030, 64'h0, 0);
    run_op("R4", 6'h1F, 5'h03, 16'h0038, 64'h0, 0);
    run_op("R4_R7", 6'h1F, 5'h06, 16'h0014, 64'h0, 0);
    // R5: set and clear
    run_op("R5", 6'h1F, 5'h0A, 16'h0028, 64'h0, 0);
    run_op("R5", 6'h1F, 5'h0F, 16'h0048, 64'h0, 0);
    run_op("R5_R8", 6'h1F, 5'h0E, 16'h004C, 64'h0, 0);
    // R6 and R3: add and swap at both widths
    run_op("R6_R3", 6'h1F, 5'h12, 16'h0040, 64'h1111_1111_FFFF_FFFF, 0);
    run_op("R6_R3", 6'h1F, 5'h13, 16'h0038, 64'h0000_0000_0000_0002, 0);
    run_op("R6_R8", 6'h1F, 5'h16, 16'h0044, 64'h5555_5555_1357_9BDF, 0);
    run_op("R6_R3", 6'h1F, 5'h17, 16'h0028, 64'h0F0E_0D0C_0B0A_0908, 0);
    // R7: returned value is the pre-update one
    run_op("R7", 6'h1F, 5'h03, 16'h0028, 64'h0, 0);
    // R9: illegal sub-codes and function code
    run_op("R9", 6'h1F, 5'h04, 16'h0048, 64'h1, 0);
    run_op("R9", 6'h1F, 5'h1B, 16'h0048, 64'h1, 0);
    run_op("R9", 6'h20, 5'h02, 16'h0048, 64'h1, 0);
    // R10: misaligned word and doubleword
    run_op("R10", 6'h1F, 5'h02, 16'h0042, 64'h0, 0);
    run_op("R10", 6'h1F, 5'h13, 16'h0044, 64'h7, 0);
    run_op("R10", 6'h19, 5'h00, 16'h0021, 64'h7, 0);
    // R11: request held while busy is ignored
    run_op("R11", 6'h1F, 5'h12, 16'h0010, 64'h0000_0000_0000_0100, 1);
    run_op("R11", 6'h1F, 5'h02, 16'h0010, 64'h0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule